// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo two's-complement serial audio stream into parallel left and right samples. It sees three wires from an external transmitter: a bit clock, a frame clock that tells the two channels apart, and a serial data line. A 3-bit format select picks the framing (LSB-justified, MSB-justified or I2S-style), the word length (16, 20 or 24 bits) and the bit-clock-per-frame ratio the stream may use. Once both words of a frame are complete, the block presents them as 24-bit left-aligned samples and raises a one-cycle valid strobe.

All three serial wires are brought into the system clock domain through synchronisers. A rising edge of the bit clock is found there, and it acts as the sampling instant. Frame-clock transitions are detected between two successive bit-clock rising edges. A bit counter places each bit of a word. In the LSB-justified formats a trailing shift window holds the most recent bits, and the block reads the word from it when the frame clock changes. The system clock must run at least four times faster than the bit clock.

Top module: `audio_serial_rx`

## Requirements
- R1: Serial data is sampled on rising edges of the bit clock, MSB first, in two's complement. Every word is delivered left-aligned in 24 bits, so the sign is kept in bit 23.
- R2: Format 0 is 16-bit LSB-justified and works with both 32 and 64 bit clocks per frame. The word's LSB is the last bit before the next frame-clock transition, and any earlier bits in that half are ignored.
- R3: Format 1 is 20-bit LSB-justified and format 4 is 24-bit LSB-justified. Both behave as in R2, with their own word length.
- R4: Formats 2 and 5 are MSB-justified. The MSB arrives on the first bit-clock rise after the frame-clock transition, and 24 bits are taken. Bits after the 24th in a half are ignored.
- R5: Formats 3 and 6 are I2S-style. The MSB arrives on the second bit-clock rise after the transition, and the last bit of a word may fall on the first rise of the next half. At 32 bit clocks per frame, format 3 delivers the 16 bits that fit.
- R6: A word shorter than 24 bits has its unused low output bits forced to zero.
- R7: In the justified formats a high frame clock marks the left channel. In the I2S formats a low frame clock marks the left channel.
- R8: Format 7 is reserved and never raises the valid strobe.
- R9: The valid strobe is high for exactly one system-clock cycle after each right word completes. It is raised only if a complete left word came directly before that right word. A right word with no left word before it gives no strobe.
- R10: The sample outputs change only in the cycle in which the valid strobe is high.
- R11: The format select is captured while reset is high. Changes after reset is released have no effect.
- R12: During reset both sample outputs are zero and the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock, asynchronous to clk |
| frame_clk | input | 1 | Channel-select (frame) clock |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 3 | Format select, captured during reset |
| left_sample | output | 24 | Left-aligned left-channel sample |
| right_sample | output | 24 | Left-aligned right-channel sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A stale or corrupted bit counter or shift window shows up as wrong sample values on the very next strobe, one frame after the fault. A wrong channel or priming state shows up as a missing strobe, a doubled strobe, or swapped channels within the first two frames after reset. Junk bits are placed outside each word, so a misplaced capture window shows up as ones in positions that should be zero or as lost sign bits. The format select is changed after every reset release, so a latch that is not frozen after reset decodes the next frame in the wrong format.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic [1:0] {
        FR_LSB = 2'd0,
        FR_MSB = 2'd1,
        FR_I2S = 2'd2,
        FR_OFF = 2'd3
    } framing_e;

    typedef struct packed {
        framing_e         framing;
        logic [CNT_W-1:0] wlen;
    } fmt_cfg_t;

    function automatic fmt_cfg_t decode_fmt(input logic [2:0] sel);
        fmt_cfg_t c;
        c.framing = FR_OFF;
        c.wlen    = CNT_W'(SAMPLE_W);
        case (sel)
            3'd0: begin c.framing = FR_LSB; c.wlen = CNT_W'(16); end
            3'd1: begin c.framing = FR_LSB; c.wlen = CNT_W'(20); end
            3'd2: c.framing = FR_MSB;
            3'd3: c.framing = FR_I2S;
            3'd4: c.framing = FR_LSB;
            3'd5: c.framing = FR_MSB;
            3'd6: c.framing = FR_I2S;
            default: c.framing = FR_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_i,
    input  logic lr_i,
    input  logic sd_i,
    output logic tick_o,
    output logic lr_o,
    output logic sd_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] chain [STAGES];
    logic            bclk_d;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= {bclk_i, lr_i, sd_i};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= chain[STAGES-1][2];
    end

    assign tick_o = chain[STAGES-1][2] & ~bclk_d;
    assign lr_o   = chain[STAGES-1][1];
    assign sd_o   = chain[STAGES-1][0];
endmodule

// File: rtl/audio_rx_framer.sv
module audio_rx_framer
    import audio_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     lr_i,
    input  framing_e framing_i,
    output logic     start_o,
    output logic     done_o,
    output logic     done_left_o
);
    logic       lr_d1;
    logic       lr_prev;
    logic [1:0] prime;
    logic       half_ok;
    logic       is_i2s;
    logic       lr_eff;

    assign is_i2s  = (framing_i == FR_I2S);
    // I2S: the effective channel select lags the frame clock by one bit
    assign lr_eff  = is_i2s ? lr_d1 : lr_i;
    assign start_o = tick_i && (prime == 2'd2) && (lr_eff != lr_prev);
    assign done_o  = start_o && half_ok;
    // justified: high = left; I2S: low = left
    assign done_left_o = lr_prev ^ is_i2s;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_d1   <= 1'b0;
            lr_prev <= 1'b0;
            prime   <= 2'd0;
            half_ok <= 1'b0;
        end else if (tick_i) begin
            lr_d1   <= lr_i;
            lr_prev <= lr_eff;
            if (prime != 2'd2) prime <= prime + 2'd1;
            if (start_o) half_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/audio_rx_capture.sv
module audio_rx_capture
    import audio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic                sd_i,
    input  fmt_cfg_t            cfg_i,
    output logic [SAMPLE_W-1:0] word_o
);
    logic [SAMPLE_W-1:0] window;
    logic [SAMPLE_W-1:0] acc, acc_n;
    logic [CNT_W-1:0]    cnt, cnt_n;
    logic [CNT_W-1:0]    shamt;

    always_comb begin
        acc_n = acc;
        cnt_n = cnt;
        if (start_i) begin
            acc_n               = '0;
            acc_n[SAMPLE_W-1]   = sd_i;
            cnt_n               = CNT_W'(1);
        end else if (cnt < CNT_W'(SAMPLE_W)) begin
            acc_n[SAMPLE_W-1-int'(cnt)] = sd_i;
            cnt_n                       = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window <= '0;
            acc    <= '0;
            cnt    <= CNT_W'(SAMPLE_W);
        end else if (tick_i) begin
            window <= {window[SAMPLE_W-2:0], sd_i};
            acc    <= acc_n;
            cnt    <= cnt_n;
        end
    end

    assign shamt  = CNT_W'(SAMPLE_W) - cfg_i.wlen;
    // LSB-justified: newest bits are the word; left-align with zero fill
    assign word_o = (cfg_i.framing == FR_LSB) ? (window << shamt) : acc;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk,
    input  logic                frame_clk,
    input  logic                ser_data,
    input  logic [2:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid
);
    logic [2:0]          fmt_q;
    fmt_cfg_t            cfg;
    logic                tick, lr_s, sd_s;
    logic                start, done, done_left;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_seen;

    always_ff @(posedge clk) begin
        if (rst) fmt_q <= fmt_sel;
    end

    assign cfg = decode_fmt(fmt_q);

    audio_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .bclk_i(bit_clk), .lr_i(frame_clk), .sd_i(ser_data),
        .tick_o(tick), .lr_o(lr_s), .sd_o(sd_s)
    );

    audio_rx_framer framer_i (
        .clk(clk), .rst(rst), .tick_i(tick), .lr_i(lr_s), .framing_i(cfg.framing),
        .start_o(start), .done_o(done), .done_left_o(done_left)
    );

    audio_rx_capture capture_i (
        .clk(clk), .rst(rst), .tick_i(tick), .start_i(start), .sd_i(sd_s),
        .cfg_i(cfg), .word_o(word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold    <= '0;
            left_seen    <= 1'b0;
            left_sample  <= '0;
            right_sample <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (done) begin
                if (done_left) begin
                    left_hold <= word;
                    left_seen <= 1'b1;
                end else begin
                    left_seen <= 1'b0;
                    if (left_seen && cfg.framing != FR_OFF) begin
                        left_sample  <= left_hold;
                        right_sample <= word;
                        sample_valid <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [23:0] left_i,
    input logic [23:0] right_i,
    input logic [2:0]  fmt_i
);
    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !valid_i);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> ($stable(left_i) && $stable(right_i)));

    p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (fmt_i == 3'd7) |-> !valid_i);

    p_fill16_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fmt_i == 3'd0) |-> (left_i[7:0] == 8'd0 && right_i[7:0] == 8'd0));

    p_fill20_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fmt_i == 3'd1) |-> (left_i[3:0] == 4'd0 && right_i[3:0] == 4'd0));

    p_fmt_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(fmt_i));
endmodule

bind audio_serial_rx audio_serial_rx_chk chk_i (
    .clk(clk), .rst(rst), .valid_i(sample_valid),
    .left_i(left_sample), .right_i(right_sample), .fmt_i(fmt_q)
);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;
    localparam int FR_LSB = 0;
    localparam int FR_MSB = 1;
    localparam int FR_I2S = 2;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [23:0] left_sample, right_sample;
    logic        sample_valid;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    exp_t q[$];
    logic pend = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    logic        prev_valid = 1'b0;
    logic [23:0] prev_l = '0, prev_r = '0;

    always #5 clk = ~clk;

    audio_serial_rx dut_i (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .frame_clk(frame_clk),
        .ser_data(ser_data), .fmt_sel(fmt_sel), .left_sample(left_sample),
        .right_sample(right_sample), .sample_valid(sample_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected pairs when the strobe fires
    always @(negedge clk) begin
        if (!rst) begin
            if (sample_valid) begin
                if (prev_valid) check(1'b0, "R9 strobe longer than one cycle", 24'd1, 24'd0);
                if (q.size() == 0) begin
                    check(1'b0, "R9 R8 unexpected strobe", right_sample, 24'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(left_sample == e.l, {e.tag, " R1 R7 left"}, left_sample, e.l);
                    check(right_sample == e.r, {e.tag, " R1 R7 right"}, right_sample, e.r);
                end
            end else if (left_sample != prev_l || right_sample != prev_r) begin
                check(1'b0, "R10 outputs moved without strobe", right_sample, prev_r);
            end
        end
        prev_valid = sample_valid;
        prev_l     = left_sample;
        prev_r     = right_sample;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic drive_bit(input logic lr, input logic sd);
        @(negedge clk);
        frame_clk = lr;
        ser_data  = sd;
        bit_clk   = 1'b0;
        repeat (3) @(negedge clk);
        bit_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // I2S is modelled as MSB-justified data delayed by one bit clock
    task automatic put_bit(input int fr, input logic lr, input logic b);
        if (fr == FR_I2S) begin
            drive_bit(lr, pend);
            pend = b;
        end else begin
            drive_bit(lr, b);
        end
    endtask

    task automatic send_half(input int fr, input int n, input int w, input logic lr, input logic [23:0] v);
        for (int k = 0; k < n; k++) begin
            logic b;
            if (fr == FR_LSB) b = (k >= n - w) ? v[n-1-k] : 1'b1;
            else              b = (k < w) ? v[w-1-k] : 1'b1;
            put_bit(fr, lr, b);
        end
    endtask

    task automatic run_mode(input logic [2:0] m, input int fr, input int bpf, input int w,
                            input bit expect_out, input string tag);
        logic left_lvl;
        left_lvl = (fr == FR_I2S) ? 1'b0 : 1'b1;
        rst = 1'b1;
        fmt_sel = m;
        bit_clk = 1'b0;
        frame_clk = ~left_lvl;
        pend = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        fmt_sel = ~m;  // R11: must be ignored after reset
        for (int i = 0; i < 4; i++) put_bit(fr, ~left_lvl, 1'b0);
        for (int f = 0; f < 3; f++) begin
            logic [23:0] lv, rv;
            exp_t e;
            seed = nxt(seed); lv = seed[31:8];
            seed = nxt(seed); rv = seed[31:8];
            if (w < 24) begin
                lv = lv & ((24'd1 << w) - 24'd1);
                rv = rv & ((24'd1 << w) - 24'd1);
            end
            if (f == 0) lv[w-1] = 1'b1;  // negative sample
            e.l = lv << (24 - w);
            e.r = rv << (24 - w);
            e.tag = tag;
            if (expect_out) q.push_back(e);
            send_half(fr, bpf / 2, w, left_lvl, lv);
            send_half(fr, bpf / 2, w, ~left_lvl, rv);
        end
        for (int i = 0; i < 4; i++) put_bit(fr, left_lvl, 1'b0);
        repeat (20) @(negedge clk);
        check(q.size() == 0, {tag, " R9 all frames delivered"}, 24'(q.size()), 24'd0);
        q.delete();
    endtask

    initial begin
        fmt_sel = 3'd5;
        repeat (5) @(negedge clk);
        // R12 reset state
        check(left_sample == 24'd0, "R12 left in reset", left_sample, 24'd0);
        check(right_sample == 24'd0, "R12 right in reset", right_sample, 24'd0);
        check(sample_valid == 1'b0, "R12 valid in reset", 24'(sample_valid), 24'd0);

        run_mode(3'd0, FR_LSB, 64, 16, 1'b1, "R2 R6 R11");
        run_mode(3'd0, FR_LSB, 32, 16, 1'b1, "R2");
        run_mode(3'd1, FR_LSB, 64, 20, 1'b1, "R3 R6");
        run_mode(3'd4, FR_LSB, 64, 24, 1'b1, "R3");
        run_mode(3'd5, FR_MSB, 64, 24, 1'b1, "R4 R11");
        run_mode(3'd2, FR_MSB, 64, 24, 1'b1, "R4");
        run_mode(3'd6, FR_I2S, 64, 24, 1'b1, "R5");
        run_mode(3'd3, FR_I2S, 32, 16, 1'b1, "R5 R6");
        run_mode(3'd7, FR_MSB, 64, 24, 1'b0, "R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule